// File: doc/BRIEF.md
# RGB LED Dimmer with Half-Period Cap

This block dims a three-colour LED whose segments light when their pin is pulled to logic 0. One free-running period counter, advanced on every rising edge of the system clock, is shared by three colour channels. Each channel compares the counter against its own duty value and pulls its pin low for that many cycles at the start of every period. It drives its pin high for the rest of the period. Mixing the three duty values gives mixed colours.

Two parameters set the period: the counter width and the last count value. The lit time of any channel is limited to half of the period, using integer division, whatever duty value is presented. This keeps the LED at or below a 50% duty cycle. Duty inputs are captured only when the counter wraps, so every period runs with one consistent setting.

Each channel holds a two-state machine. In state DARK the pin is high. In state LIT the pin is low. The transition *light* (DARK to LIT) is taken when the next counter value is below the next effective duty. The transition *extinguish* (LIT to DARK) is taken when it is not. Reset forces DARK.

Top module: `rgb_dimmer`

## Requirements
- R1: The period counter runs 0, 1, …, CNT_MAX and then returns to 0, so one period lasts CNT_MAX+1 clock cycles.
- R2: Within a period, a channel's pin is low (LED on) exactly during the cycles where the counter is below that channel's effective duty. The low phase therefore opens the period and is contiguous.
- R3: The effective duty is min(duty, (CNT_MAX+1)/2). A duty request above that cap yields exactly (CNT_MAX+1)/2 low cycles per period, and the pin is always high once the counter reaches the cap.
- R4: The three channels are independent: each pin's low time depends only on its own duty input.
- R5: A duty of 0 keeps the pin high for the whole period.
- R6: Synchronous active-high reset clears the counter and the captured duties and holds all pins high. The first period after reset is fully dark.
- R7: Duty inputs are captured only on the cycle where the counter wraps from CNT_MAX to 0. A change made partway through a period has no effect until the next period.
- R8: For the same duty, a larger CNT_MAX gives a longer period (CNT_MAX+1 cycles) and a smaller low fraction. Both width 3 / last count 7 and width 4 / last count 10 are supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one counter step per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| duty_r | input | CNT_W | Requested lit cycles per period, red |
| duty_g | input | CNT_W | Requested lit cycles per period, green |
| duty_b | input | CNT_W | Requested lit cycles per period, blue |
| led_r_n | output | 1 | Red pin, low = lit |
| led_g_n | output | 1 | Green pin, low = lit |
| led_b_n | output | 1 | Blue pin, low = lit |

## Verification
Some properties are checked on every cycle:
- the counter stays in range and wraps to zero;
- a pin is never low once the counter reaches the half-period cap;
- a zero effective duty keeps the pin high;
- the captured duty holds still except at a wrap;
- reset drives every pin high.

Other behaviour only the bench scenarios can show: the exact count and placement of low cycles per period for each channel, mid-period duty changes taking effect one period later, and the period length differing between the two parameter sets. The bench sweeps all duty values for both configurations, with different values on each channel at once.

// File: rtl/dim_pkg.sv
package dim_pkg;

    localparam int NUM_CH = 3;

    typedef enum logic {
        ST_DARK = 1'b0,
        ST_LIT  = 1'b1
    } lamp_state_t;

endpackage

// File: rtl/dim_period.sv
module dim_period #(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 10
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CNT_MAX);

    always_comb begin
        wrap    = (cnt_q == LAST);
        cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

    // R1: counter never leaves 0..CNT_MAX
    p_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R1: last count is followed by zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/dim_channel.sv
module dim_channel
    import dim_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic             wrap,
    input  logic [CNT_W-1:0] duty,
    output logic             led_n
);

    localparam logic [CNT_W-1:0] HALF = CNT_W'((CNT_MAX + 1) / 2);

    lamp_state_t      state_q, state_nxt;
    logic [CNT_W-1:0] eff_q, eff_nxt, capped;
    logic             lit_next;

    always_comb begin
        capped   = (duty > HALF) ? HALF : duty;
        eff_nxt  = wrap ? capped : eff_q;
        lit_next = (cnt_nxt < eff_nxt);
    end

    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_DARK: if (lit_next)  state_nxt = ST_LIT;   // light
            ST_LIT:  if (!lit_next) state_nxt = ST_DARK;  // extinguish
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_DARK;
            eff_q   <= '0;
        end else begin
            state_q <= state_nxt;
            eff_q   <= eff_nxt;
        end
    end

    always_comb begin
        led_n = (state_q != ST_LIT);
    end

    // R3: lit time capped at half the period
    p_cap_r3: assert property (@(posedge clk) disable iff (rst)
        (cnt_q >= HALF) |-> led_n);

    p_eff_cap_r3: assert property (@(posedge clk) disable iff (rst)
        eff_q <= HALF);

    // R2: low while the counter is below the captured duty
    p_lit_r2: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < eff_q) |-> !led_n);

    // R5: zero duty keeps the pin high
    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (eff_q == '0) |-> led_n);

    // R7: captured duty only moves at a wrap
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(eff_q));

    // R6: reset leaves the pin high
    p_rst_dark_r6: assert property (@(posedge clk)
        rst |=> led_n);

endmodule

// File: rtl/rgb_dimmer.sv
module rgb_dimmer
    import dim_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] duty_r,
    input  logic [CNT_W-1:0] duty_g,
    input  logic [CNT_W-1:0] duty_b,
    output logic             led_r_n,
    output logic             led_g_n,
    output logic             led_b_n
);

    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             wrap;
    logic [CNT_W-1:0] duty_arr [NUM_CH];
    logic             led_arr  [NUM_CH];

    always_comb begin
        duty_arr[0] = duty_r;
        duty_arr[1] = duty_g;
        duty_arr[2] = duty_b;
    end

    dim_period #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_period (
        .clk     (clk),
        .rst     (rst),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dim_channel #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .cnt_q   (cnt_q),
            .cnt_nxt (cnt_nxt),
            .wrap    (wrap),
            .duty    (duty_arr[ch]),
            .led_n   (led_arr[ch])
        );
    end

    always_comb begin
        led_r_n = led_arr[0];
        led_g_n = led_arr[1];
        led_b_n = led_arr[2];
    end

endmodule

// File: tb/sim_rgb_dimmer.sv
module sim_rgb_dimmer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] a_r = 4'd5, a_g = 4'd9, a_b = 4'd3;
    logic [2:0] b_r = 3'd6, b_g = 3'd2, b_b = 3'd7;
    logic a_rn, a_gn, a_bn, b_rn, b_gn, b_bn;
    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    always #5 clk = ~clk;

    rgb_dimmer #(.CNT_W(4), .CNT_MAX(10)) u0 (
        .clk(clk), .rst(rst), .duty_r(a_r), .duty_g(a_g), .duty_b(a_b),
        .led_r_n(a_rn), .led_g_n(a_gn), .led_b_n(a_bn));

    rgb_dimmer #(.CNT_W(3), .CNT_MAX(7)) u1 (
        .clk(clk), .rst(rst), .duty_r(b_r), .duty_g(b_g), .duty_b(b_b),
        .led_r_n(b_rn), .led_g_n(b_gn), .led_b_n(b_bn));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] led_of(input int which);
        return (which == 0) ? {a_rn, a_gn, a_bn} : {b_rn, b_gn, b_bn};
    endfunction

    function automatic int pick(input int which, input int d, input int c);
        int m = (which == 0) ? 16 : 8;
        int k = d % m;
        if (c == 0) return k;
        if (c == 1) return (which == 0) ? (k * 7 + 3) % 16 : (k * 3 + 1) % 8;
        return m - 1 - k;
    endfunction

    task automatic set_duty(input int which, input int d);
        if (which == 0) begin
            a_r = 4'(pick(0, d, 0)); a_g = 4'(pick(0, d, 1)); a_b = 4'(pick(0, d, 2));
        end else begin
            b_r = 3'(pick(1, d, 0)); b_g = 3'(pick(1, d, 1)); b_b = 3'(pick(1, d, 2));
        end
    endtask

    // one period of samples starting at the negedge where the counter is 0;
    // prev < 0 means the captured duties are zero (right after reset)
    task automatic measure(input int which, input int prev, input int nxt);
        int  mx   = (which == 0) ? 10 : 7;
        int  p    = mx + 1;
        int  half = p / 2;
        int  req [3];
        int  exp [3];
        int  lows[3] = '{0, 0, 0};
        bit  shp [3] = '{1'b1, 1'b1, 1'b1};
        for (int c = 0; c < 3; c++) begin
            req[c] = (prev < 0) ? 0 : pick(which, prev, c);
            exp[c] = (req[c] > half) ? half : req[c];
        end
        for (int i = 0; i < p; i++) begin
            logic [2:0] bits = led_of(which);
            for (int c = 0; c < 3; c++) begin
                bit low = !bits[2 - c];
                if (low) lows[c]++;
                if (low != (i < exp[c])) shp[c] = 1'b0;
            end
            if (i == p / 2) set_duty(which, nxt);  // mid-period change: R7
            @(negedge clk);
        end
        for (int c = 0; c < 3; c++) begin
            string base;
            if (prev < 0)          base = "R6";
            else if (req[c] == 0)  base = "R5";
            else if (req[c] > half) base = "R3";
            else                   base = "R2";
            chk(shp[c] && lows[c] == exp[c],
                $sformatf("%s R4 R7 dut%0d ch%0d req=%0d", base, which, c, req[c]),
                lows[c], exp[c]);
        end
    endtask

    // R1 R8: distance between two falling edges of the green pin
    task automatic gap(input int which);
        int  p = (which == 0) ? 11 : 8;
        int  n = 0;
        logic prv = led_of(which)[1];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (prv && !led_of(which)[1]) break;
            prv = led_of(which)[1];
        end
        prv = led_of(which)[1];
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            n++;
            if (prv && !led_of(which)[1]) break;
            prv = led_of(which)[1];
        end
        chk(n == p, $sformatf("R1 R8 period dut%0d", which), n, p);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({a_rn, a_gn, a_bn, b_rn, b_gn, b_bn} == 6'h3f, "R6 reset pins high", 
            int'({a_rn, a_gn, a_bn, b_rn, b_gn, b_bn}), 63);
        rst = 1'b0;
        measure(0, -1, 0);
        for (int d = 0; d < 16; d++) measure(0, d, d + 1);
        gap(0);

        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        chk({a_rn, a_gn, a_bn} == 3'b111, "R6 mid-run reset pins high",
            int'({a_rn, a_gn, a_bn}), 7);
        rst = 1'b0;
        measure(1, -1, 0);
        for (int d = 0; d < 8; d++) measure(1, d, d + 1);
        gap(1);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule